// File: doc/BRIEF.md
# Serial Flash Identification and Performance-Mode Command Responder

This block is the device-side command front end of a single-bit SPI serial flash in mode 0. After chip select goes low it shifts an 8-bit opcode in on rising SCLK edges, most significant bit first. It then either streams a 24-bit identifier, counts the dummy bytes of the high-performance-mode entry command, or prepares a power-down or wake transition. A transition is applied on the first rising SCLK edge that sees chip select high.

The identifier is three elaboration-time bytes: a vendor code, a memory-type byte and a capacity byte. They are sent in that order, one bit per falling SCLK edge, and they repeat for as long as clocks keep arriving. The high-performance flag and the power-down state are outputs, so a status-register read path can use them. A `busy` input stands for an erase or program cycle in progress. While it is high, the identification opcode is not decoded.

The block runs on SCLK and expects the clock to toggle for at least one rising edge while chip select is high after each command. Chip select is sampled on that edge.

Top module: `spi_id_responder`

## Requirements
- R1: While `rst_n` is low, and after it is released, `hpm_flag`, `pwr_down` and `so_oe` are 0.
- R2: Opcode 0x9F, received while `busy` is 0 and outside power-down, drives the identifier on `so` with `so_oe` at 1. The identifier is `ID_VALUE[23:16]` (vendor), then `[15:8]` (type), then `[7:0]` (capacity), most significant bit first. The first bit is driven on the falling edge that follows the eighth opcode rising edge, and one new bit follows on each later falling edge.
- R3: If chip select stays low after the 24th identifier bit, the identifier starts again from bit 23.
- R4: `so_oe` is 0 whenever `cs_n` is high, including when chip select rises in the middle of the identifier. The next command after that decodes normally.
- R5: Opcode 0x9F whose eighth bit is sampled while `busy` is 1 is dropped. `so_oe` stays 0 and the flags do not change.
- R6: Opcode 0xA3, followed by exactly `DUMMY_BYTES` (default 3) whole bytes and then chip select rising on a byte boundary, sets `hpm_flag`. A different byte count, or a partial byte, leaves it unchanged.
- R7: Opcode 0xAB, sent as exactly one byte, clears both `hpm_flag` and `pwr_down`. Extra bits or bytes cancel it.
- R8: Opcode 0xB9, sent as exactly one byte, sets `pwr_down` and clears `hpm_flag`.
- R9: While `pwr_down` is 1, every opcode except 0xAB is ignored. `so_oe` stays 0 and `hpm_flag` does not change.
- R10: Any other opcode is ignored until chip select goes high. The following command decodes normally.
- R11: `hpm_flag` and `pwr_down` change only on a rising SCLK edge at which `cs_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; inputs are sampled on the rising edge and `so` changes on the falling edge |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| busy | input | 1 | High while an erase or program cycle is in progress |
| so | output | 1 | Serial data out; 0 when `so_oe` is 0 |
| so_oe | output | 1 | Output enable for the `so` pad; 0 means high-impedance |
| hpm_flag | output | 1 | High-performance-mode status bit |
| pwr_down | output | 1 | Deep power-down state |

## Verification
The hardest situations to reach are the commit rules. Chip select has to rise after exactly one, four, or some other number of whole bytes, or part of the way through a byte, and each of these must be checked against both flags. The stimulus runs a ladder of near-miss transactions: 0xA3 with two dummy bytes, 0xA3 with three dummy bytes plus four bits, and 0xAB with a second byte. The same ladder is run again while in power-down. A behavioural model in the bench predicts `so`, `so_oe` and both flags on every clock.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;
   localparam logic [7:0] OPC_READ_ID   = 8'h9F;
   localparam logic [7:0] OPC_HPM_ENTER = 8'hA3;
   localparam logic [7:0] OPC_WAKE      = 8'hAB;
   localparam logic [7:0] OPC_SLEEP     = 8'hB9;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_IDENT,
      CMD_HPM,
      CMD_WAKE,
      CMD_SLEEP,
      CMD_DROP
   } cmd_e;
endpackage

// File: rtl/spi_id_rx.sv
// Input shifter: counts bits and whole bytes inside one chip-select session.
module spi_id_rx #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              si,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val,
   output logic [CNT_W-1:0]  bytes_seen,
   output logic              aligned,
   output logic              sess_end
);
   localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh_q;
   logic [BIT_W-1:0]  bit_q;
   logic [CNT_W-1:0]  bytes_q;
   logic              act_q;

   assign byte_val   = {sh_q[BYTE_W-2:0], si};
   assign byte_done  = !cs_n && (bit_q == LAST_BIT);
   assign aligned    = (bit_q == '0);
   assign sess_end   = cs_n && act_q;
   assign bytes_seen = bytes_q;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         bit_q   <= '0;
         bytes_q <= '0;
         act_q   <= 1'b0;
      end else if (cs_n) begin
         bit_q   <= '0;
         bytes_q <= '0;
         act_q   <= 1'b0;
      end else begin
         act_q <= 1'b1;
         sh_q  <= byte_val;
         if (byte_done) begin
            bit_q <= '0;
            if (!(&bytes_q)) bytes_q <= bytes_q + 1'b1;
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_id_ctrl.sv
// Opcode decode and mode state; flags commit when chip select is seen high.
module spi_id_ctrl
   import spi_id_pkg::*;
#(
   parameter int CNT_W       = 3,
   parameter int DUMMY_BYTES = 3
) (
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             cs_n,
   input  logic             busy,
   input  logic             byte_done,
   input  logic [7:0]       byte_val,
   input  logic [CNT_W-1:0] bytes_seen,
   input  logic             aligned,
   input  logic             sess_end,
   output logic             ident_on,
   output logic             hpm_flag,
   output logic             pwr_down
);
   localparam logic [CNT_W-1:0] HPM_LEN = CNT_W'(DUMMY_BYTES + 1);
   localparam logic [CNT_W-1:0] ONE_LEN = CNT_W'(1);

   cmd_e cmd_q;
   cmd_e cmd_dec;
   logic hpm_q, pd_q;

   always_comb begin
      cmd_dec = CMD_DROP;
      if (pd_q) begin
         if (byte_val == OPC_WAKE) cmd_dec = CMD_WAKE;
      end else begin
         case (byte_val)
            OPC_READ_ID:   cmd_dec = busy ? CMD_DROP : CMD_IDENT;
            OPC_HPM_ENTER: cmd_dec = CMD_HPM;
            OPC_WAKE:      cmd_dec = CMD_WAKE;
            OPC_SLEEP:     cmd_dec = CMD_SLEEP;
            default:       cmd_dec = CMD_DROP;
         endcase
      end
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= CMD_NONE;
         hpm_q <= 1'b0;
         pd_q  <= 1'b0;
      end else if (cs_n) begin
         cmd_q <= CMD_NONE;
         if (sess_end && aligned) begin
            case (cmd_q)
               CMD_HPM: if (bytes_seen == HPM_LEN) hpm_q <= 1'b1;
               CMD_WAKE: if (bytes_seen == ONE_LEN) begin
                  hpm_q <= 1'b0;
                  pd_q  <= 1'b0;
               end
               CMD_SLEEP: if (bytes_seen == ONE_LEN) begin
                  hpm_q <= 1'b0;
                  pd_q  <= 1'b1;
               end
               default: ;
            endcase
         end
      end else if (byte_done && (bytes_seen == '0)) begin
         cmd_q <= cmd_dec;
      end
   end

   assign ident_on = (cmd_q == CMD_IDENT);
   assign hpm_flag = hpm_q;
   assign pwr_down = pd_q;
endmodule

// File: rtl/spi_id_tx.sv
// Identifier serializer on the falling SCLK edge, wrapping after the last bit.
module spi_id_tx #(
   parameter int ID_W = 24
) (
   input  logic            rst_n,
   input  logic            sclk,
   input  logic            cs_n,
   input  logic            ident_on,
   input  logic [ID_W-1:0] id_word,
   output logic            so,
   output logic            so_oe
);
   localparam int PTR_W = $clog2(ID_W);
   localparam logic [PTR_W-1:0] TOP = PTR_W'(ID_W - 1);

   logic [PTR_W-1:0] ptr_q;
   logic             so_q, drv_q;

   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= TOP;
         so_q  <= 1'b0;
         drv_q <= 1'b0;
      end else if (ident_on && !cs_n) begin
         drv_q <= 1'b1;
         so_q  <= id_word[ptr_q];
         ptr_q <= (ptr_q == '0) ? TOP : ptr_q - 1'b1;
      end else begin
         drv_q <= 1'b0;
         ptr_q <= TOP;
      end
   end

   assign so_oe = drv_q & ~cs_n;
   assign so    = so_q & so_oe;
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder #(
   parameter int BYTE_W      = 8,
   parameter int ID_BYTES    = 3,
   parameter logic [ID_BYTES*BYTE_W-1:0] ID_VALUE = 24'hC84014,
   parameter int DUMMY_BYTES = 3
) (
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic si,
   input  logic busy,
   output logic so,
   output logic so_oe,
   output logic hpm_flag,
   output logic pwr_down
);
   localparam int ID_W  = ID_BYTES * BYTE_W;
   localparam int CNT_W = $clog2(DUMMY_BYTES + 3);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("spi_id_responder: opcodes are 8 bits wide");
      end
      if (ID_BYTES < 1) begin : g_bad_id
         $error("spi_id_responder: identifier needs at least one byte");
      end
      if (DUMMY_BYTES < 0 || DUMMY_BYTES > 12) begin : g_bad_dummy
         $error("spi_id_responder: dummy byte count out of range");
      end
   endgenerate

   logic [ID_W-1:0]   id_word;
   logic              byte_done, aligned, sess_end, ident_on;
   logic [BYTE_W-1:0] byte_val;
   logic [CNT_W-1:0]  bytes_seen;

   for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
      assign id_word[g*BYTE_W +: BYTE_W] = ID_VALUE[g*BYTE_W +: BYTE_W];
   end

   spi_id_rx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) rx_i (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
      .byte_done(byte_done), .byte_val(byte_val), .bytes_seen(bytes_seen),
      .aligned(aligned), .sess_end(sess_end)
   );

   spi_id_ctrl #(.CNT_W(CNT_W), .DUMMY_BYTES(DUMMY_BYTES)) ctrl_i (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(busy),
      .byte_done(byte_done), .byte_val(byte_val), .bytes_seen(bytes_seen),
      .aligned(aligned), .sess_end(sess_end),
      .ident_on(ident_on), .hpm_flag(hpm_flag), .pwr_down(pwr_down)
   );

   spi_id_tx #(.ID_W(ID_W)) tx_i (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .ident_on(ident_on),
      .id_word(id_word), .so(so), .so_oe(so_oe)
   );
endmodule

// File: rtl/spi_id_responder_chk.sv
module spi_id_responder_chk (
   input logic rst_n,
   input logic sclk,
   input logic cs_n,
   input logic so_oe,
   input logic hpm_flag,
   input logic pwr_down
);
   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!so_oe);
      end
   end

   assert_oe_off_when_deselected_R4: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |-> !so_oe);

   assert_hpm_set_at_deselect_R6: assert property (@(posedge sclk) disable iff (!rst_n)
      $rose(hpm_flag) |-> ($past(cs_n) && !pwr_down));

   assert_wake_clears_hpm_R7: assert property (@(posedge sclk) disable iff (!rst_n)
      $fell(pwr_down) |-> !hpm_flag);

   assert_sleep_clears_hpm_R8: assert property (@(posedge sclk) disable iff (!rst_n)
      $rose(pwr_down) |-> !hpm_flag);

   assert_silent_in_sleep_R9: assert property (@(posedge sclk) disable iff (!rst_n)
      pwr_down |-> !so_oe);

   assert_flags_move_on_deselect_R11: assert property (@(posedge sclk) disable iff (!rst_n)
      ((hpm_flag != $past(hpm_flag)) || (pwr_down != $past(pwr_down))) |-> $past(cs_n));
endmodule

bind spi_id_responder spi_id_responder_chk chk_i (
   .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .so_oe(so_oe),
   .hpm_flag(hpm_flag), .pwr_down(pwr_down)
);

// File: tb/spi_id_responder_tb_top.sv
`timescale 1ns/100ps
module spi_id_responder_tb_top;
   localparam logic [23:0] ID_EXP = 24'hC84014;
   localparam int M_NONE = 0, M_ID = 1, M_HPM = 2, M_WAKE = 3, M_SLEEP = 4, M_DROP = 5;

   logic rst_n, sclk, cs_n, si, busy;
   logic so, so_oe, hpm_flag, pwr_down;

   int checks = 0;
   int errors = 0;

   // reference model state
   int   m_bits = 0;
   int   m_cmd  = M_NONE;
   logic [7:0] m_op = 8'h00;
   bit   m_hpf = 0;
   bit   m_pd  = 0;
   bit   id_q[$];
   logic [23:0] got_word;
   int   oe_seen;

   spi_id_responder #(.ID_VALUE(ID_EXP), .DUMMY_BYTES(3)) dut_i (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si), .busy(busy),
      .so(so), .so_oe(so_oe), .hpm_flag(hpm_flag), .pwr_down(pwr_down)
   );

   initial sclk = 1'b0;
   always #2 sclk = ~sclk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic model_rise(input logic c, input logic d, input logic b);
      if (c) begin
         if (m_bits > 0 && (m_bits % 8) == 0) begin
            if (m_cmd == M_HPM && m_bits / 8 == 4) m_hpf = 1;
            if (m_cmd == M_WAKE && m_bits / 8 == 1) begin m_hpf = 0; m_pd = 0; end
            if (m_cmd == M_SLEEP && m_bits / 8 == 1) begin m_hpf = 0; m_pd = 1; end
         end
         m_bits = 0;
         m_cmd  = M_NONE;
      end else begin
         m_op = {m_op[6:0], d};
         m_bits++;
         if (m_bits == 8) begin
            if (m_pd) m_cmd = (m_op == 8'hAB) ? M_WAKE : M_DROP;
            else if (m_op == 8'h9F) m_cmd = b ? M_DROP : M_ID;
            else if (m_op == 8'hA3) m_cmd = M_HPM;
            else if (m_op == 8'hAB) m_cmd = M_WAKE;
            else if (m_op == 8'hB9) m_cmd = M_SLEEP;
            else m_cmd = M_DROP;
            if (m_cmd == M_ID) begin
               id_q.delete();
               for (int i = 23; i >= 0; i--) id_q.push_back(ID_EXP[i]);
            end
         end
      end
   endtask

   // one SCLK period: drive after the falling edge, compare SO, then compare flags after the rising edge
   task automatic step(input logic c, input logic d);
      bit exp_oe;
      bit exp_bit;
      @(negedge sclk);
      #0.5;
      cs_n = c;
      si   = d;
      #0.5;
      exp_oe = !c && (m_cmd == M_ID);
      chk(c ? "R4" : "R2", {31'd0, so_oe}, {31'd0, exp_oe});
      if (exp_oe) begin
         exp_bit = id_q.pop_front();
         id_q.push_back(exp_bit);
         chk("R2", {31'd0, so}, {31'd0, exp_bit});
         got_word = {got_word[22:0], so};
         oe_seen++;
      end
      @(posedge sclk);
      model_rise(c, d, busy);
      #0.5;
      chk("R6", {31'd0, hpm_flag}, {31'd0, m_hpf});
      chk("R8", {31'd0, pwr_down}, {31'd0, m_pd});
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) step(1'b0, b[i]);
   endtask

   task automatic deselect();
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
   endtask

   task automatic clocks(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge sclk);
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; si = 1'b0; busy = 1'b0;
      repeat (3) @(posedge sclk);
      #0.5;
      chk("R1 oe", {31'd0, so_oe}, 0);
      chk("R1 hpm", {31'd0, hpm_flag}, 0);
      chk("R1 pd", {31'd0, pwr_down}, 0);
      @(negedge sclk);
      rst_n = 1'b1;
      deselect();
      chk("R1 after release", {30'd0, hpm_flag, pwr_down}, 0);

      // R2 and R3: identifier sent twice in one session
      oe_seen = 0;
      send_byte(8'h9F);
      clocks(24);
      chk("R2 id word", {8'd0, got_word}, {8'd0, ID_EXP});
      clocks(24);
      chk("R3 repeated id", {8'd0, got_word}, {8'd0, ID_EXP});
      chk("R3 bits driven", oe_seen, 48);
      deselect();

      // R4: chip select rises in the middle of the identifier
      oe_seen = 0;
      send_byte(8'h9F);
      clocks(10);
      deselect();
      chk("R4 cut after 10", oe_seen, 10);
      chk("R4 oe low", {31'd0, so_oe}, 0);

      // R5: identification while busy
      oe_seen = 0;
      busy = 1'b1;
      send_byte(8'h9F);
      clocks(16);
      deselect();
      busy = 1'b0;
      chk("R5 no output while busy", oe_seen, 0);

      // R6: exact HPM entry, then near misses
      send_byte(8'hA3); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
      deselect();
      chk("R6 hpm set", {31'd0, hpm_flag}, 1);
      send_byte(8'hAB);
      deselect();
      chk("R7 wake clears hpm", {31'd0, hpm_flag}, 0);
      send_byte(8'hA3); send_byte(8'h00); send_byte(8'h00);
      deselect();
      chk("R6 two dummies", {31'd0, hpm_flag}, 0);
      send_byte(8'hA3); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
      clocks(4);
      deselect();
      chk("R6 partial byte", {31'd0, hpm_flag}, 0);
      send_byte(8'hA3); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
      deselect();
      chk("R6 four dummies", {31'd0, hpm_flag}, 0);

      // R10: unknown opcode, then a normal command
      send_byte(8'hA3); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF);
      deselect();
      oe_seen = 0;
      send_byte(8'h05); send_byte(8'hAB); send_byte(8'hB9);
      deselect();
      chk("R10 unknown ignored", {30'd0, hpm_flag, pwr_down}, 2'b10);
      chk("R10 no output", oe_seen, 0);

      // R7: wake with a trailing byte is cancelled
      send_byte(8'hAB); send_byte(8'h00);
      deselect();
      chk("R7 extra byte cancels", {31'd0, hpm_flag}, 1);

      // R8: sleep clears hpm
      send_byte(8'hB9);
      deselect();
      chk("R8 pd set", {30'd0, hpm_flag, pwr_down}, 2'b01);

      // R9: commands in power-down
      oe_seen = 0;
      send_byte(8'h9F);
      clocks(24);
      deselect();
      chk("R9 id ignored", oe_seen, 0);
      send_byte(8'hA3); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
      deselect();
      chk("R9 hpm ignored", {30'd0, hpm_flag, pwr_down}, 2'b01);
      send_byte(8'hB9);
      deselect();
      send_byte(8'hAB);
      clocks(3);
      deselect();
      chk("R7 partial wake", {31'd0, pwr_down}, 1);

      // R11: wake commits only once chip select is sampled high
      send_byte(8'hAB);
      #0.5;
      chk("R11 before deselect", {31'd0, pwr_down}, 1);
      deselect();
      chk("R7 wake", {31'd0, pwr_down}, 0);

      // identification works again after wake
      oe_seen = 0;
      send_byte(8'h9F);
      clocks(24);
      deselect();
      chk("R2 after wake", {8'd0, got_word}, {8'd0, ID_EXP});

      summary();
   end
endmodule